// File: doc/BRIEF.md
# NAND Page Store with AND-Programming and Block Erase

This block is the storage back end of a NAND device model. It keeps a small array of pages. Each page row is a main area followed by a spare area whose size is the main size divided by 32. Three kinds of request reach it: a page load that streams the bytes of one row out, a page program that streams bytes in, and a block erase. A fourth request sets a one-shot start offset. The next program adds that offset to its column, and the offset then returns to zero.

Programming never overwrites a byte. Each stored byte becomes the AND of its old value and the new value, so a program can only move bits from 1 to 0. An erase returns every main and spare byte of a power-of-two group of pages to 0xFF. Requests whose page lies beyond the array are acknowledged and have no effect.

All traffic goes through one single-port byte memory, one byte per clock. After reset the block sweeps the whole array to 0xFF while it holds busy high.

Top module: `nand_store`

## Requirements
- R1: After reset, busy_o is high while the array is initialised, one byte per cycle. Once busy_o falls, every byte of every page, main and spare, reads 0xFF.
- R2: A row holds PAGE_BYTES main bytes followed by PAGE_BYTES>>5 spare bytes. A load (req_op_i = 0) from column c streams bytes c through the last spare byte, which is ROW_BYTES-c bytes. A load with c >= ROW_BYTES streams nothing.
- R3: A program (req_op_i = 1) leaves each written byte equal to its stored value AND the supplied byte.
- R4: A program writes min(req_len_i, ROW_BYTES-start) bytes starting at start = req_col_i + the stored start offset. Byte k is taken from wr_data_i while wr_idx_o = k. Bytes outside that range, and all other pages, are left unchanged.
- R5: A set-offset request (req_op_i = 3) stores req_col_i as the start offset. Any program to an in-range page clears that offset when it completes.
- R6: An erase (req_op_i = 2) clears the low ERASE_SHIFT bits of the page index. It then sets all main and spare bytes of the 2^ERASE_SHIFT pages from that aligned page to 0xFF, and leaves other pages unchanged.
- R7: A load, program or erase whose page index is at or beyond NUM_PAGES changes no byte and streams no data. An erase is judged on its aligned page. done_o still pulses one cycle after acceptance.
- R8: A request accepted at clock edge E that moves n bytes processes byte k at edge E+1+k. A loaded byte appears on rd_data_o with rd_valid_o after that edge. done_o pulses after edge E+n, together with the last loaded byte, with busy_o already low. A request that moves no bytes pulses done_o after edge E.
- R9: A request is accepted only on an edge where busy_o is low. A request held on req_valid_i while busy_o is high is taken after done_o, and its data reflects the finished earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; accepted on an edge where busy_o is low |
| req_op_i | input | 2 | 0 load, 1 program, 2 erase, 3 set start offset |
| req_page_i | input | PAGE_AW | Page index, one bit wider than needed so out-of-range pages can be expressed |
| req_col_i | input | COL_W | Column offset within the row, or the offset value for op 3 |
| req_len_i | input | LEN_W | Number of bytes to program |
| wr_data_i | input | 8 | Program byte for the current wr_idx_o, valid in the same cycle |
| wr_idx_o | output | LEN_W | Index of the program byte being consumed |
| busy_o | output | 1 | Initialisation or a multi-byte request in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| rd_valid_o | output | 1 | rd_data_o holds a loaded byte |
| rd_data_o | output | 8 | Loaded byte |

## Verification
Every result is due a fixed number of edges after the accepting edge E. Loaded byte k appears after edge E+1+k. done_o of an n-byte request appears after edge E+n, or after E for a request that moves no bytes. The bench drives and samples on falling edges and numbers each falling edge from acceptance. It checks that done_o arrives at exactly index n+1 (or 1), and that loaded bytes arrive in order on consecutive indices. Array content is compared against a model that is updated only when a request has finished, and every row is read back through loads.

// File: rtl/nand_store_pkg.sv
package nand_store_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BASE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_LOAD
  } state_e;

  function automatic int spare_of(int page_bytes);
    return page_bytes >> 5;
  endfunction
endpackage

// File: rtl/nand_store_mem.sv
module nand_store_mem #(
  parameter int DEPTH = 2112,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // read is combinational so read-modify-write fits one cycle
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/nand_store_seq.sv
module nand_store_seq
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int NUM_PAGES   = 32,
  parameter int ERASE_SHIFT = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_valid_i,
  input  logic [1:0]                            req_op_i,
  input  logic [$clog2(NUM_PAGES):0]            req_page_i,
  input  logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5))-1:0] req_col_i,
  input  logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1)-1:0] req_len_i,
  input  logic [7:0]                            wr_data_i,
  input  logic [7:0]                            mem_rdata_i,
  output logic [$clog2((PAGE_BYTES+(PAGE_BYTES>>5))*NUM_PAGES)-1:0] mem_addr_o,
  output logic                                  mem_we_o,
  output logic [7:0]                            mem_wdata_o,
  output logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1)-1:0] wr_idx_o,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic                                  rd_valid_o,
  output logic [7:0]                            rd_data_o,
  output logic                                  prog_act_o
);
  localparam int SPARE_BYTES = spare_of(PAGE_BYTES);
  localparam int ROW_BYTES   = PAGE_BYTES + SPARE_BYTES;
  localparam int MEM_BYTES   = ROW_BYTES * NUM_PAGES;
  localparam int MEM_AW      = $clog2(MEM_BYTES);
  localparam int PAGE_AW     = $clog2(NUM_PAGES) + 1;
  localparam int COL_W       = $clog2(ROW_BYTES);
  localparam int LEN_W       = $clog2(ROW_BYTES + 1);
  localparam int BLK_BYTES   = ROW_BYTES << ERASE_SHIFT;
  localparam int CNT_W       = $clog2(MEM_BYTES + 1);

  state_e             state_q;
  logic [MEM_AW-1:0]  addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LEN_W-1:0]   idx_q;
  logic [COL_W-1:0]   base_q;
  logic               done_q;
  logic               rd_valid_q;
  logic [7:0]         rd_data_q;

  // request decode
  logic [PAGE_AW-1:0] blk_pg;
  logic               pg_ok, blk_ok, load_ok, prog_ok;
  logic [MEM_AW-1:0]  row_base, blk_base;
  logic [COL_W:0]     prog_start;
  logic [CNT_W-1:0]   prog_room, prog_cnt, load_cnt;

  always_comb begin
    blk_pg     = {req_page_i[PAGE_AW-1:ERASE_SHIFT], {ERASE_SHIFT{1'b0}}};
    pg_ok      = req_page_i < PAGE_AW'(NUM_PAGES);
    blk_ok     = blk_pg < PAGE_AW'(NUM_PAGES);
    row_base   = MEM_AW'(req_page_i) * MEM_AW'(ROW_BYTES);
    blk_base   = MEM_AW'(blk_pg) * MEM_AW'(ROW_BYTES);
    prog_start = {1'b0, req_col_i} + {1'b0, base_q};
    prog_room  = CNT_W'(ROW_BYTES) - CNT_W'(prog_start);
    prog_cnt   = (CNT_W'(req_len_i) < prog_room) ? CNT_W'(req_len_i) : prog_room;
    load_cnt   = CNT_W'(ROW_BYTES) - CNT_W'(req_col_i);
    load_ok    = pg_ok && (req_col_i < COL_W'(ROW_BYTES));
    prog_ok    = pg_ok && (prog_start < (COL_W+1)'(ROW_BYTES)) && (req_len_i != '0);
  end

  logic last;
  assign last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT;
      addr_q     <= '0;
      cnt_q      <= CNT_W'(MEM_BYTES);
      idx_q      <= '0;
      base_q     <= '0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (last) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid_i) begin
            unique case (op_e'(req_op_i))
              OP_BASE: begin
                base_q <= req_col_i;
                done_q <= 1'b1;
              end
              OP_PROG: begin
                if (prog_ok) begin
                  addr_q  <= row_base + MEM_AW'(prog_start);
                  cnt_q   <= prog_cnt;
                  idx_q   <= '0;
                  state_q <= ST_PROG;
                end else begin
                  done_q <= 1'b1;
                  if (pg_ok) base_q <= '0;
                end
              end
              OP_ERASE: begin
                if (blk_ok) begin
                  addr_q  <= blk_base;
                  cnt_q   <= CNT_W'(BLK_BYTES);
                  state_q <= ST_ERASE;
                end else begin
                  done_q <= 1'b1;
                end
              end
              default: begin
                if (load_ok) begin
                  addr_q  <= row_base + MEM_AW'(req_col_i);
                  cnt_q   <= load_cnt;
                  state_q <= ST_LOAD;
                end else begin
                  done_q <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_PROG: begin
          addr_q <= addr_q + 1'b1;
          idx_q  <= idx_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            base_q  <= '0;
          end
        end
        ST_ERASE: begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= mem_rdata_i;
          addr_q     <= addr_q + 1'b1;
          cnt_q      <= cnt_q - 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = (state_q == ST_INIT) || (state_q == ST_PROG) || (state_q == ST_ERASE);
  assign mem_wdata_o = (state_q == ST_PROG) ? (mem_rdata_i & wr_data_i) : 8'hFF;
  assign wr_idx_o    = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign prog_act_o  = (state_q == ST_PROG);
endmodule

// File: rtl/nand_store.sv
module nand_store
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int NUM_PAGES   = 32,
  parameter int ERASE_SHIFT = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_valid_i,
  input  logic [1:0]                            req_op_i,
  input  logic [$clog2(NUM_PAGES):0]            req_page_i,
  input  logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5))-1:0] req_col_i,
  input  logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1)-1:0] req_len_i,
  input  logic [7:0]                            wr_data_i,
  output logic [$clog2(PAGE_BYTES+(PAGE_BYTES>>5)+1)-1:0] wr_idx_o,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic                                  rd_valid_o,
  output logic [7:0]                            rd_data_o
);
  localparam int ROW_BYTES = PAGE_BYTES + spare_of(PAGE_BYTES);
  localparam int MEM_BYTES = ROW_BYTES * NUM_PAGES;
  localparam int MEM_AW    = $clog2(MEM_BYTES);
  localparam int LEN_W     = $clog2(ROW_BYTES + 1);

  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              prog_act;

  nand_store_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES),
    .ERASE_SHIFT(ERASE_SHIFT)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (req_op_i),
    .req_page_i (req_page_i),
    .req_col_i  (req_col_i),
    .req_len_i  (req_len_i),
    .wr_data_i  (wr_data_i),
    .mem_rdata_i(mem_rdata),
    .mem_addr_o (mem_addr),
    .mem_we_o   (mem_we),
    .mem_wdata_o(mem_wdata),
    .wr_idx_o   (wr_idx_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .prog_act_o (prog_act)
  );

  nand_store_mem #(
    .DEPTH(MEM_BYTES),
    .AW   (MEM_AW)
  ) i_mem (
    .clk_i  (clk_i),
    .addr_i (mem_addr),
    .we_i   (mem_we),
    .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/nand_store_chk.sv
module nand_store_chk #(
  parameter int LEN_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_valid_o,
  input logic             prog_act,
  input logic [LEN_W-1:0] wr_idx_o
);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_last_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !busy_o) |-> done_o);

  assert_rd_in_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(busy_o));

  assert_start_on_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_act && $past(prog_act)) |-> (wr_idx_o == $past(wr_idx_o) + 1'b1));
endmodule

bind nand_store nand_store_chk #(.LEN_W(LEN_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rd_valid_o (rd_valid_o),
  .prog_act   (prog_act),
  .wr_idx_o   (wr_idx_o)
);

// File: tb/test_nand_store.sv
module test_nand_store;
  localparam int PB   = 64;
  localparam int NP   = 32;
  localparam int ES   = 4;
  localparam int ROW  = PB + (PB >> 5);
  localparam int MB   = ROW * NP;
  localparam int BP   = 1 << ES;
  localparam int PAW  = $clog2(NP) + 1;
  localparam int COLW = $clog2(ROW);
  localparam int LENW = $clog2(ROW + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = '0;
  logic [PAW-1:0]  req_page = '0;
  logic [COLW-1:0] req_col = '0;
  logic [LENW-1:0] req_len = '0;
  logic [7:0]      wr_data;
  logic [LENW-1:0] wr_idx;
  logic            busy, done, rd_valid;
  logic [7:0]      rd_data;

  int seed = 0;
  int base = 0;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] mdl [MB];
  logic [7:0] got [ROW];
  int n_got, done_at;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int s, int k);
    return 8'(k * 37 + s * 13 + 5);
  endfunction

  always_comb wr_data = pat(seed, int'(wr_idx));

  nand_store #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .ERASE_SHIFT(ES)) i_nand_store (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_page_i(req_page), .req_col_i(req_col), .req_len_i(req_len),
    .wr_data_i(wr_data), .wr_idx_o(wr_idx), .busy_o(busy), .done_o(done),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // drive one request, collect streamed bytes, note falling-edge index of done
  task automatic run(int op, int page, int col, int len);
    wait_idle();
    req_op = 2'(op); req_page = PAW'(page); req_col = COLW'(col); req_len = LENW'(len);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_got = 0; done_at = 0;
    for (int i = 1; i < 3000; i++) begin
      if (rd_valid && n_got < ROW) begin got[n_got] = rd_data; n_got++; end
      if (done) begin done_at = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_load(int page, int col, string req);
    int n;
    n = (page < NP && col < ROW) ? ROW - col : 0;
    run(0, page, col, 0);
    chk({req, " load length"}, n_got, n);
    chk("R8 load done cycle", done_at, (n > 0) ? n + 1 : 1);
    for (int k = 0; k < n && k < n_got; k++)
      chk({req, " load byte"}, int'(got[k]), int'(mdl[page * ROW + col + k]));
  endtask

  task automatic do_prog(int page, int col, int len, int s);
    int st, n;
    seed = s;
    st = col + base;
    n = (page < NP && st < ROW) ? ((len < ROW - st) ? len : ROW - st) : 0;
    run(1, page, col, len);
    chk("R8 program done cycle", done_at, (n > 0) ? n + 1 : 1);
    for (int k = 0; k < n; k++) mdl[page * ROW + st + k] &= pat(s, k);
    if (page < NP) base = 0;
  endtask

  task automatic do_erase(int page);
    int bp;
    bp = page & ~(BP - 1);
    run(2, page, 0, 0);
    chk("R8 erase done cycle", done_at, (bp < NP) ? BP * ROW + 1 : 1);
    if (bp < NP) for (int k = bp * ROW; k < (bp + BP) * ROW; k++) mdl[k] = 8'hFF;
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < NP; p++) do_load(p, 0, req);
  endtask

  initial begin
    for (int k = 0; k < MB; k++) mdl[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: init sweep holds busy for the whole array
    chk("R1 busy after reset", int'(busy), 1);
    chk("R1 no done during init", int'(done), 0);
    chk("R1 no read during init", int'(rd_valid), 0);
    sweep("R1");

    // R2: length from column, spare-only tail, column past row
    do_load(5, 60, "R2");
    do_load(6, PB, "R2");
    do_load(7, ROW - 1, "R2");
    do_load(8, ROW + 3, "R2");

    // R3: repeated programs AND into the row
    do_prog(3, 0, ROW, 1);
    do_load(3, 0, "R3");
    do_prog(3, 0, ROW, 2);
    do_load(3, 0, "R3");
    do_prog(3, 0, ROW, 9);
    do_load(3, 0, "R3");

    // R4: partial program, truncation at row end, neighbours untouched
    do_prog(7, 10, 20, 4);
    do_prog(7, 60, 20, 5);
    do_prog(8, 0, 0, 6);
    do_prog(8, ROW + 1, 5, 6);
    do_load(7, 0, "R4");
    do_load(8, 0, "R4");
    do_load(6, 0, "R4");

    // R5: one-shot start offset
    run(3, 0, 16, 0);
    base = 16;
    chk("R5 offset done cycle", done_at, 1);
    do_prog(9, 4, 5, 7);
    do_prog(9, 4, 3, 8);
    do_load(9, 0, "R5");
    run(3, 0, 30, 0);
    base = 30;
    do_prog(10, 0, 4, 12);
    do_prog(10, 0, 4, 13);
    do_load(10, 0, "R5");

    // R6: erase from mid-block page aligns down, spare included
    do_prog(20, 0, ROW, 10);
    do_prog(31, 50, 16, 11);
    do_erase(18);
    sweep("R6");

    // R7: out-of-range requests
    do_prog(40, 0, ROW, 3);
    do_erase(33);
    do_erase(63);
    do_load(50, 0, "R7");
    do_load(32, 0, "R7");
    sweep("R7");

    // R9: request held while an erase runs is taken after done
    wait_idle();
    req_op = 2'd2; req_page = PAW'(2); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < BP * ROW; k++) mdl[k] = 8'hFF;
    req_op = 2'd0; req_page = PAW'(3); req_col = '0;
    n_got = 0;
    for (int i = 1; i < 3000; i++) begin
      if (rd_valid) n_got++;
      if (done) break;
      @(negedge clk);
    end
    chk("R9 no data before done", n_got, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 held request accepted", int'(busy), 1);
    n_got = 0;
    for (int i = 1; i < 3000; i++) begin
      if (rd_valid) begin got[n_got] = rd_data; n_got++; end
      if (done) break;
      @(negedge clk);
    end
    chk("R9 held load length", n_got, ROW);
    for (int k = 0; k < ROW; k++) chk("R9 held load byte", int'(got[k]), int'(mdl[3 * ROW + k]));
    sweep("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule